// File: doc/BRIEF.md
# Per-Port Link Status and Interrupt Register Bank

This block is the software-visible register bank of a multi-port serial-link wrapper. It has sixteen port positions, and only positions 6 to 15 can be populated. Each 32-bit status word packs two 16-bit per-port vectors. Numbering is ascending from the most significant bit, so the bit at MSB-first index n, which is Verilog bit 31-n, belongs to port n in the upper half. Verilog bit 15-n belongs to port n in the lower half. The bank reports whether each port is used, its transmit lock, channel-up and back-pressure state, and the not-ready flags of its inbound and outbound streams. A writable enable word gates the dataflow of each stream.

Link error pulses from each port pass through a rising-edge detector into a sticky 32-bit interrupt status word. Software clears that word by writing 1s to it. A per-bit mask and a global enable combine the captured bits into one interrupt line. A keyed write to the reset region starts a soft reset of fixed length. A small state machine with two states carries it out. ST_RUN is normal operation. ST_FLUSH is soft reset in progress. ST_RUN goes to ST_FLUSH on a write of the key. ST_FLUSH goes back to ST_RUN when its cycle counter reaches the programmed length.

The bus is a plain single-cycle register interface. A write takes effect on the clock edge where `wr_en` is high. Read data is a combinational function of `addr`.

Top module: `lnkreg_bank`

## Requirements
- R1: After `rst_n` is released, the enable word, the interrupt status, the interrupt mask and the global enable are all zero, `in_en`/`out_en` are zero and `irq` is low.
- R2: Reading byte offset 0x000 returns `port_used[n]` at Verilog bit 31-n and `tx_lock[n]` at bit 15-n for n = 6..15. Bits for ports 0..5 read 0.
- R3: Reading offset 0x004 returns `chan_up[n]` at bit 31-n and `back_pres[n]` at bit 15-n for the live ports, with the same zero rule for ports 0..5.
- R4: Offset 0x008 returns `in_src_nrdy[n]` at bit 31-n and `out_src_nrdy[n]` at bit 15-n. Offset 0x00C returns `in_dst_nrdy[n]` at bit 31-n and `out_dst_nrdy[n]` at bit 15-n. Ports 0..5 read 0.
- R5: Offset 0x010 is read/write. Written bit 31-n drives `in_en[n]` and bit 15-n drives `out_en[n]`, both from the next cycle on. Positions for ports 0..5 stay 0, and reads return the stored word.
- R6: Writes to the read-only offsets 0x000–0x00C, and to any offset not listed here, change nothing. Reads of unlisted offsets, including 0x100, return zero.
- R7: A 0→1 change of `err_hs[n]` between two clock edges sets status bit 31-n, and one of `err_frame[n]` sets bit 15-n. A level held high sets the bit only once. Ports 0..5 never set a bit.
- R8: The interrupt status at 0x200 is sticky. Writing it clears every bit written as 1. A new event in the same cycle as a clear of its bit leaves the bit set.
- R9: `irq` is high exactly when global enable (offset 0x208, bit 0) is 1 and some bit is set both in the status and in the mask at 0x204. Both 0x204 and 0x208 are read/write.
- R10: Writing 0x000000A5 to 0x100 in ST_RUN starts a soft reset. From the next cycle the enable word, status, mask and global enable read zero. The following 16 clock edges ignore all bus writes and capture no events. Edge history keeps tracking, so a level that stays high across the reset raises no event. Any other value written to 0x100 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 10 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| port_used | input | 16 | Port configured as active |
| tx_lock | input | 16 | Transmit lock per port |
| chan_up | input | 16 | Channel up per port |
| back_pres | input | 16 | Receive buffer asserting back pressure |
| in_src_nrdy | input | 16 | Inbound stream source not ready |
| out_src_nrdy | input | 16 | Outbound stream source not ready (transmit buffer empty) |
| in_dst_nrdy | input | 16 | Inbound stream destination not ready (receive buffer full) |
| out_dst_nrdy | input | 16 | Outbound stream destination not ready |
| err_hs | input | 16 | Hard or soft link error per port |
| err_frame | input | 16 | Frame error per port |
| in_en | output | 16 | Inbound dataflow enable per port |
| out_en | output | 16 | Outbound dataflow enable per port |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is the soft-reset window. During it, bus writes, error edges and clears must all be dropped while edge history still advances. Two cases are hard to distinguish from the ports. One is an error level raised inside the window and held past its end. The other is a level raised right after the window, which must still be captured. The stimulus writes the key and then issues writes and error edges on chosen cycles inside the window. One error level is kept high through the exit, and the bench then looks for the status bit staying clear. The same-cycle collision of an event with its write-1 clear is also timed by driving the rising edge on the very cycle of the clear write.

// File: rtl/lnkreg_pkg.sv
package lnkreg_pkg;

    localparam int LR_NPORT     = 16;
    localparam int LR_PORT_LO   = 6;
    localparam int LR_AW        = 10;
    localparam int LR_FLUSH_CYC = 16;
    localparam logic [31:0] LR_SRST_KEY = 32'h0000_00A5;

    localparam int OFF_STAT0 = 'h000;
    localparam int OFF_STAT1 = 'h004;
    localparam int OFF_SRDY  = 'h008;
    localparam int OFF_DRDY  = 'h00C;
    localparam int OFF_EN    = 'h010;
    localparam int OFF_SRST  = 'h100;
    localparam int OFF_IST   = 'h200;
    localparam int OFF_IEN   = 'h204;
    localparam int OFF_GEN   = 'h208;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } srst_st_t;

endpackage

// File: rtl/lnkreg_ctrl.sv
module lnkreg_ctrl
    import lnkreg_pkg::*;
#(
    parameter int          AW        = LR_AW,
    parameter int          DW        = 32,
    parameter int          FLUSH_CYC = LR_FLUSH_CYC,
    parameter logic [31:0] KEY       = LR_SRST_KEY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          srst_req,
    output logic          flush
);
    localparam int CW = $clog2(FLUSH_CYC + 1);

    srst_st_t        st_q, st_d;
    logic [CW-1:0]   cnt_q;
    logic            key_hit;

    assign key_hit = wr_en && (addr == AW'(OFF_SRST)) && (wdata == DW'(KEY));

    // state register and window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_q == ST_FLUSH) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   if (key_hit) st_d = ST_FLUSH;
            ST_FLUSH: if (cnt_q == CW'(FLUSH_CYC - 1)) st_d = ST_RUN;
            default:  st_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        flush    = (st_q == ST_FLUSH);
        srst_req = (st_q == ST_RUN) && key_hit;
    end

endmodule

// File: rtl/lnkreg_irq.sv
module lnkreg_irq
    import lnkreg_pkg::*;
#(
    parameter int NPORT   = LR_NPORT,
    parameter int PORT_LO = LR_PORT_LO,
    localparam int DW     = 2 * NPORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             w1c_en,
    input  logic [DW-1:0]    w1c_mask,
    input  logic [NPORT-1:0] err_hs,
    input  logic [NPORT-1:0] err_frame,
    output logic [DW-1:0]    ist
);
    logic [NPORT-1:0] hs_q, fr_q;
    logic [DW-1:0]    evt;

    // edge history advances in every state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '0;
            fr_q <= '0;
        end else begin
            hs_q <= err_hs;
            fr_q <= err_frame;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_evt
        if (p >= PORT_LO) begin : g_live
            assign evt[DW-1-p]    = err_hs[p] & ~hs_q[p];
            assign evt[NPORT-1-p] = err_frame[p] & ~fr_q[p];
        end else begin : g_dead
            assign evt[DW-1-p]    = 1'b0;
            assign evt[NPORT-1-p] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ist <= '0;
        else if (clr)
            ist <= '0;
        else
            ist <= (ist & ~(w1c_en ? w1c_mask : '0)) | evt;
    end

endmodule

// File: rtl/lnkreg_bank.sv
module lnkreg_bank
    import lnkreg_pkg::*;
#(
    parameter int          NPORT     = LR_NPORT,
    parameter int          PORT_LO   = LR_PORT_LO,
    parameter int          AW        = LR_AW,
    parameter int          FLUSH_CYC = LR_FLUSH_CYC,
    parameter logic [31:0] KEY       = LR_SRST_KEY,
    localparam int         DW        = 2 * NPORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [NPORT-1:0] port_used,
    input  logic [NPORT-1:0] tx_lock,
    input  logic [NPORT-1:0] chan_up,
    input  logic [NPORT-1:0] back_pres,
    input  logic [NPORT-1:0] in_src_nrdy,
    input  logic [NPORT-1:0] out_src_nrdy,
    input  logic [NPORT-1:0] in_dst_nrdy,
    input  logic [NPORT-1:0] out_dst_nrdy,
    input  logic [NPORT-1:0] err_hs,
    input  logic [NPORT-1:0] err_frame,
    output logic [NPORT-1:0] in_en,
    output logic [NPORT-1:0] out_en,
    output logic             irq
);
    localparam logic [NPORT-1:0] PORT_MASK = ~NPORT'((1 << PORT_LO) - 1);

    function automatic logic [DW-1:0] pair(input logic [NPORT-1:0] a,
                                           input logic [NPORT-1:0] b);
        logic [DW-1:0] w;
        w = '0;
        for (int p = 0; p < NPORT; p++) begin
            w[DW-1-p]    = a[p] & PORT_MASK[p];
            w[NPORT-1-p] = b[p] & PORT_MASK[p];
        end
        return w;
    endfunction

    logic             srst_req, flush, clr, wr_ok;
    logic [DW-1:0]    ist_q, ien_q;
    logic             gen_q;
    logic [NPORT-1:0] en_in_q, en_out_q, wr_in, wr_out;

    lnkreg_ctrl #(
        .AW(AW), .DW(DW), .FLUSH_CYC(FLUSH_CYC), .KEY(KEY)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .srst_req(srst_req), .flush(flush)
    );

    assign clr   = srst_req | flush;
    assign wr_ok = wr_en & ~flush;

    lnkreg_irq #(
        .NPORT(NPORT), .PORT_LO(PORT_LO)
    ) u_irq (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .w1c_en(wr_ok && (addr == AW'(OFF_IST))), .w1c_mask(wdata),
        .err_hs(err_hs), .err_frame(err_frame), .ist(ist_q)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_unpack
        assign wr_in[p]  = wdata[DW-1-p] & PORT_MASK[p];
        assign wr_out[p] = wdata[NPORT-1-p] & PORT_MASK[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_in_q  <= '0;
            en_out_q <= '0;
            ien_q    <= '0;
            gen_q    <= 1'b0;
        end else if (clr) begin
            en_in_q  <= '0;
            en_out_q <= '0;
            ien_q    <= '0;
            gen_q    <= 1'b0;
        end else if (wr_ok) begin
            if (addr == AW'(OFF_EN)) begin
                en_in_q  <= wr_in;
                en_out_q <= wr_out;
            end
            if (addr == AW'(OFF_IEN)) ien_q <= wdata;
            if (addr == AW'(OFF_GEN)) gen_q <= wdata[0];
        end
    end

    always_comb begin
        case (addr)
            AW'(OFF_STAT0): rdata = pair(port_used, tx_lock);
            AW'(OFF_STAT1): rdata = pair(chan_up, back_pres);
            AW'(OFF_SRDY):  rdata = pair(in_src_nrdy, out_src_nrdy);
            AW'(OFF_DRDY):  rdata = pair(in_dst_nrdy, out_dst_nrdy);
            AW'(OFF_EN):    rdata = pair(en_in_q, en_out_q);
            AW'(OFF_IST):   rdata = ist_q;
            AW'(OFF_IEN):   rdata = ien_q;
            AW'(OFF_GEN):   rdata = DW'(gen_q);
            default:        rdata = '0;
        endcase
    end

    assign in_en  = en_in_q;
    assign out_en = en_out_q;
    assign irq    = gen_q & |(ist_q & ien_q);

endmodule

// File: rtl/lnkreg_chk.sv
module lnkreg_chk
    import lnkreg_pkg::*;
#(
    parameter int          NPORT     = LR_NPORT,
    parameter int          AW        = LR_AW,
    parameter int          FLUSH_CYC = LR_FLUSH_CYC,
    parameter logic [31:0] KEY       = LR_SRST_KEY,
    localparam int         DW        = 2 * NPORT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    addr,
    input logic [DW-1:0]    wdata,
    input logic [NPORT-1:0] in_en,
    input logic [NPORT-1:0] out_en,
    input logic             irq,
    input logic             flush,
    input logic             srst_req,
    input logic [DW-1:0]    ist
);
    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_len <= 0;
        else if (flush) run_len <= run_len + 1;
        else            run_len <= 0;
    end

    assert_en_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == AW'(OFF_EN)) && !flush && !srst_req)
        |=> ($stable(in_en) && $stable(out_en)));

    assert_ist_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == AW'(OFF_IST)) && !flush && !srst_req)
        |=> ((ist & $past(ist)) == $past(ist)));

    assert_irq_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ist != '0));

    assert_flush_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= FLUSH_CYC);

    assert_flush_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush) |-> $past(wr_en && addr == AW'(OFF_SRST) && wdata == DW'(KEY)));

    assert_flush_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (in_en == '0 && out_en == '0 && ist == '0 && !irq));

endmodule

bind lnkreg_bank lnkreg_chk #(
    .NPORT(NPORT), .AW(AW), .FLUSH_CYC(FLUSH_CYC), .KEY(KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .in_en(in_en), .out_en(out_en), .irq(irq), .flush(flush),
    .srst_req(srst_req), .ist(ist_q)
);

// File: tb/sim_lnkreg_bank.sv
`timescale 1ns/1ps
module sim_lnkreg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] port_used = '0, tx_lock = '0, chan_up = '0, back_pres = '0;
    logic [15:0] in_src_nrdy = '0, out_src_nrdy = '0, in_dst_nrdy = '0, out_dst_nrdy = '0;
    logic [15:0] err_hs = '0, err_frame = '0;
    logic [15:0] in_en, out_en;
    logic        irq;

    int    vectors = 0;
    int    miscompares = 0;
    bit    finished = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    lnkreg_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .port_used(port_used), .tx_lock(tx_lock),
        .chan_up(chan_up), .back_pres(back_pres), .in_src_nrdy(in_src_nrdy),
        .out_src_nrdy(out_src_nrdy), .in_dst_nrdy(in_dst_nrdy),
        .out_dst_nrdy(out_dst_nrdy), .err_hs(err_hs), .err_frame(err_frame),
        .in_en(in_en), .out_en(out_en), .irq(irq)
    );

    // behavioural reference state
    bit [15:0] m_in, m_out, m_hs, m_fr;
    bit [31:0] m_ist, m_ien;
    bit        m_gen;
    int        m_left;

    function automatic bit [31:0] join2(input bit [15:0] a, input bit [15:0] b);
        bit [31:0] w = '0;
        for (int p = 6; p < 16; p++) begin
            w[31-p] = a[p];
            w[15-p] = b[p];
        end
        return w;
    endfunction

    function automatic bit [31:0] m_read(input bit [9:0] a);
        case (a)
            10'h000: return join2(port_used, tx_lock);
            10'h004: return join2(chan_up, back_pres);
            10'h008: return join2(in_src_nrdy, out_src_nrdy);
            10'h00C: return join2(in_dst_nrdy, out_dst_nrdy);
            10'h010: return join2(m_in, m_out);
            10'h200: return m_ist;
            10'h204: return m_ien;
            10'h208: return {31'b0, m_gen};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit        key, busy;
        bit [31:0] evt;
        if (!rst_n) begin
            m_in = 0; m_out = 0; m_hs = 0; m_fr = 0;
            m_ist = 0; m_ien = 0; m_gen = 0; m_left = 0;
        end else begin
            busy = (m_left > 0);
            key  = wr_en && addr == 10'h100 && wdata == 32'hA5 && !busy;
            evt  = 0;
            for (int p = 6; p < 16; p++) begin
                evt[31-p] = err_hs[p] && !m_hs[p];
                evt[15-p] = err_frame[p] && !m_fr[p];
            end
            if (key || busy) begin
                m_in = 0; m_out = 0; m_ist = 0; m_ien = 0; m_gen = 0;
            end else begin
                if (wr_en && addr == 10'h200) m_ist = m_ist & ~wdata;
                m_ist = m_ist | evt;
                if (wr_en && addr == 10'h010)
                    for (int p = 6; p < 16; p++) begin
                        m_in[p]  = wdata[31-p];
                        m_out[p] = wdata[15-p];
                    end
                if (wr_en && addr == 10'h204) m_ien = wdata;
                if (wr_en && addr == 10'h208) m_gen = wdata[0];
            end
            m_hs = err_hs;
            m_fr = err_frame;
            if (key) m_left = 16;
            else if (busy) m_left = m_left - 1;
        end
    end

    task automatic compare();
        bit [31:0] exp_rd = m_read(addr);
        bit        exp_irq = m_gen && ((m_ist & m_ien) != 0);
        vectors++;
        if (rdata !== exp_rd) begin
            miscompares++;
            $display("FAIL %s rdata @%03h actual %08h expected %08h", cur_req, addr, rdata, exp_rd);
        end
        if (in_en !== m_in || out_en !== m_out) begin
            miscompares++;
            $display("FAIL %s enables actual %04h/%04h expected %04h/%04h",
                     cur_req, in_en, out_en, m_in, m_out);
        end
        if (irq !== exp_irq) begin
            miscompares++;
            $display("FAIL %s irq actual %0b expected %0b", cur_req, irq, exp_irq);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input bit [9:0] a, input bit [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        tick();
        wr_en = 0;
    endtask

    task automatic rd(input bit [9:0] a);
        addr = a;
        tick();
    endtask

    // explicit readback check, named by requirement
    task automatic expect_rd(input bit [9:0] a, input bit [31:0] e);
        addr = a;
        @(posedge clk);
        @(negedge clk);
        compare();
        vectors++;
        if (rdata !== e) begin
            miscompares++;
            $display("FAIL %s readback @%03h actual %08h expected %08h", cur_req, a, rdata, e);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        cur_req = "R1";
        expect_rd(10'h010, 32'h0);
        expect_rd(10'h200, 32'h0);
        expect_rd(10'h208, 32'h0);

        // R2: status word 0, ports 0..5 masked
        cur_req = "R2";
        port_used = 16'hFFFF; tx_lock = 16'h0000;
        expect_rd(10'h000, 32'h03FF_0000);
        port_used = 16'h8040; tx_lock = 16'h4001;
        expect_rd(10'h000, 32'h0201_0002);

        // R3: status word 1
        cur_req = "R3";
        chan_up = 16'h0FC0; back_pres = 16'hF03F;
        expect_rd(10'h004, 32'h03F0_000F);

        // R4: ready flag words
        cur_req = "R4";
        in_src_nrdy = 16'h0100; out_src_nrdy = 16'h0200;
        expect_rd(10'h008, 32'h0080_0040);
        in_dst_nrdy = 16'hAAAA; out_dst_nrdy = 16'h5555;
        expect_rd(10'h00C, 32'h0155_02AA);

        // R5: enable word
        cur_req = "R5";
        wr(10'h010, 32'hFFFF_FFFF);
        expect_rd(10'h010, 32'h03FF_03FF);
        wr(10'h010, 32'h0200_0001);
        expect_rd(10'h010, 32'h0200_0001);

        // R6: read-only and unmapped
        cur_req = "R6";
        wr(10'h000, 32'hFFFF_FFFF);
        wr(10'h00C, 32'hFFFF_FFFF);
        wr(10'h014, 32'hFFFF_FFFF);
        wr(10'h104, 32'h0000_00A5);
        wr(10'h300, 32'hFFFF_FFFF);
        expect_rd(10'h010, 32'h0200_0001);
        expect_rd(10'h014, 32'h0);
        expect_rd(10'h100, 32'h0);
        expect_rd(10'h2FC, 32'h0);

        // R7: edge capture
        cur_req = "R7";
        addr = 10'h200;
        err_hs = 16'h0041;
        tick(); tick(); tick();
        err_hs = 16'h0000; err_frame = 16'h8000;
        tick();
        err_frame = 16'h0;
        expect_rd(10'h200, 32'h0200_0001);

        // R8: write-one-to-clear, collision
        cur_req = "R8";
        wr(10'h200, 32'h0200_0000);
        expect_rd(10'h200, 32'h0000_0001);
        err_frame = 16'h8000;
        wr(10'h200, 32'h0000_0001);
        err_frame = 16'h0;
        expect_rd(10'h200, 32'h0000_0001);

        // R9: masking
        cur_req = "R9";
        wr(10'h204, 32'h0000_0001);
        rd(10'h200);
        wr(10'h208, 32'h1);
        rd(10'h204);
        wr(10'h204, 32'h8000_0000);
        rd(10'h204);
        err_hs = 16'h0040;
        tick();
        err_hs = 16'h0;
        expect_rd(10'h200, 32'h0200_0001);
        wr(10'h204, 32'h0200_0000);
        rd(10'h200);
        wr(10'h208, 32'h0);
        rd(10'h208);

        // R10: soft reset
        cur_req = "R10";
        wr(10'h208, 32'h1);
        wr(10'h100, 32'h0000_00A4);
        expect_rd(10'h204, 32'h0200_0000);
        wr(10'h100, 32'h0000_00A5);
        expect_rd(10'h200, 32'h0);
        wr(10'h010, 32'hFFFF_FFFF);
        err_hs = 16'h0080;
        wr(10'h204, 32'hFFFF_FFFF);
        err_frame = 16'h0400;
        repeat (14) rd(10'h010);
        err_hs = 16'h0;
        repeat (3) rd(10'h200);
        expect_rd(10'h200, 32'h0);
        err_hs = 16'h0100;
        tick();
        err_hs = 16'h0; err_frame = 16'h0;
        expect_rd(10'h200, 32'h0080_0000);
        wr(10'h010, 32'h0040_0040);
        expect_rd(10'h010, 32'h0040_0040);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule